// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Unit

This block gives each hart of a cluster two interrupt sources. The first is a per-hart software-interrupt flag that any bus master can set or clear. The second is a timer interrupt. It is raised while the hart's 64-bit deadline is at or below a shared 64-bit time counter. The time counter starts at zero and advances by one on every clock in which `tick_en` is high. `tick_en` stands for the timebase clock.

All state is reached through a 32-bit register bus made of a request strobe, a write enable, an address and write data. Read data and the error flag come back on the clock after the request. There are three address regions, each at its own base. The software-interrupt region has one 4-byte slot per hart, and the hart index is the offset divided by 4. The deadline region has one 8-byte slot per hart: offset 0 holds bits 31:0 and offset 4 holds bits 63:32. The time region is two words, with the low word at the base and the high word at base+4. Only aligned 32-bit little-endian accesses have an effect. Any other access reads as zero, changes nothing and raises a one-cycle error pulse.

Top module: `core_timer_unit`

## Requirements
- R1: A write to the aligned software-interrupt slot of hart h (address SWI_BASE + 4*h) sets `soft_irq[h]` from the following clock onward to 1 if the written word is nonzero, and to 0 if it is zero.
- R2: A read of that slot returns 32'h1 when `soft_irq[h]` is set and 32'h0 when it is clear. Read data appears on `bus_rdata` one clock after the request. On any clock that follows something other than a read request, `bus_rdata` is zero.
- R3: The deadline of hart h reads back at CMP_BASE + 8*h (bits 31:0) and at CMP_BASE + 8*h + 4 (bits 63:32).
- R4: A write to one half of a deadline replaces only those 32 bits and leaves the other half unchanged. With no write, no deadline changes.
- R5: `timer_irq[h]` is 1 exactly when, on the previous clock, the deadline of hart h was less than or equal to the time counter, as unsigned 64-bit values. A write of a deadline at or below the current time therefore raises the line. A write above the current time lowers it.
- R6: The time counter reads at TIME_BASE (bits 31:0) and at TIME_BASE + 4 (bits 63:32).
- R7: Writes to either time word leave the counter unchanged.
- R8: The time counter resets to 0. It increments by exactly 1 on each clock with `tick_en` high and holds on all other clocks.
- R9: A read at a misaligned offset inside a slot, or at an address outside the three regions, returns 0. A write there changes no register.
- R10: `bus_err` is high for exactly the one clock after any request that is unmapped or misaligned, or that writes a time word. It is low after every other request and after idle clocks.
- R11: While reset is held, all interrupt outputs, `bus_rdata` and `bus_err` are 0. All deadlines and software flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time counter advance enable |
| bus_req | input | 1 | Access request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the request |
| bus_err | output | 1 | Bad-access pulse, one clock after the request |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt level |

## Verification
The hardest case to reach is the exact boundary where a deadline equals the running time. The counter moves on its own, so a deadline aimed at the boundary is easily already in the past when it lands. The bench holds `tick_en` low and reads both time words. It then writes the deadline equal to that value, rewrites it one above, and releases a single tick. The line has to go high, then low, then high again, each on the clock computed by the bench. Random accesses mix mapped, misaligned and unmapped addresses with short bursts of ticks, and their deadlines are biased toward small values so that both comparison outcomes occur.

// File: rtl/ctu_pkg.sv
// Package: shared types for the core-local timer unit.
// Assumes a 32-bit bus and a 64-bit time base (two bus words).
package ctu_pkg;

    localparam int BUS_W  = 32;
    localparam int TIME_W = 64;

    // Decoded target of a bus access
    typedef enum logic [2:0] {
        RG_NONE    = 3'd0,
        RG_BADOFF  = 3'd1,
        RG_SWI     = 3'd2,
        RG_CMP_LO  = 3'd3,
        RG_CMP_HI  = 3'd4,
        RG_TIME_LO = 3'd5,
        RG_TIME_HI = 3'd6
    } ctu_region_e;

    // True when an access to region r with write flag we must be flagged
    function automatic logic access_faults(ctu_region_e r, logic we);
        return (r == RG_NONE) || (r == RG_BADOFF) ||
               (we && ((r == RG_TIME_LO) || (r == RG_TIME_HI)));
    endfunction

endpackage

// File: rtl/ctu_addr_decode.sv
// Module: ctu_addr_decode
// Maps a byte address to a register region and a hart index.
// Assumes the three regions do not overlap and no region wraps past
// the top of the address space. Purely combinational.
module ctu_addr_decode
    import ctu_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_HARTS = 4,
    parameter int                HART_W    = 2,
    parameter logic [ADDR_W-1:0] SWI_BASE  = 16'h1000,
    parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h4000,
    parameter logic [ADDR_W-1:0] TIME_BASE = 16'hBFF8
) (
    input  logic [ADDR_W-1:0] addr,
    output ctu_region_e       region,
    output logic [HART_W-1:0] hart
);

    localparam logic [ADDR_W-1:0] SWI_SPAN = ADDR_W'(NUM_HARTS * 4);
    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(NUM_HARTS * 8);
    localparam logic [ADDR_W-1:0] TIME_HI_ADDR = TIME_BASE + ADDR_W'(4);

    logic [ADDR_W-1:0] swi_off;
    logic [ADDR_W-1:0] cmp_off;

    // Offsets wrap to large values below a base, so one compare checks range
    always_comb begin
        swi_off = addr - SWI_BASE;
        cmp_off = addr - CMP_BASE;
    end

    // Region and hart selection
    always_comb begin
        region = RG_NONE;
        hart   = '0;
        if (swi_off < SWI_SPAN) begin
            hart   = swi_off[HART_W+1:2];
            region = (swi_off[1:0] == 2'b00) ? RG_SWI : RG_BADOFF;
        end else if (cmp_off < CMP_SPAN) begin
            hart = cmp_off[HART_W+2:3];
            case (cmp_off[2:0])
                3'd0:    region = RG_CMP_LO;
                3'd4:    region = RG_CMP_HI;
                default: region = RG_BADOFF;
            endcase
        end else if (addr == TIME_BASE) begin
            region = RG_TIME_LO;
        end else if (addr == TIME_HI_ADDR) begin
            region = RG_TIME_HI;
        end
    end

endmodule

// File: rtl/ctu_time_base.sv
// Module: ctu_time_base
// Free-running time counter that advances by one per enabled clock.
// Assumes tick_en is already synchronous to clk. Not writable.
module ctu_time_base #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [TIME_W-1:0] time_q
);

    // Count enabled clocks, wrapping modulo 2**TIME_W
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (tick_en) begin
            time_q <= time_q + TIME_W'(1);
        end
    end

endmodule

// File: rtl/ctu_hart_slot.sv
// Module: ctu_hart_slot
// State of one hart: software flag, 64-bit deadline, timer level.
// Assumes at most one of the write strobes is high per clock.
module ctu_hart_slot #(
    parameter int BUS_W  = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swi_we,
    input  logic              cmp_lo_we,
    input  logic              cmp_hi_we,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [TIME_W-1:0] time_now,
    output logic              soft_q,
    output logic              timer_q,
    output logic [TIME_W-1:0] cmp_q
);

    // Software flag follows whether the written word is nonzero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (swi_we) begin
            soft_q <= |wdata;
        end
    end

    // Deadline halves written independently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_lo_we) begin
            cmp_q[BUS_W-1:0] <= wdata;
        end else if (cmp_hi_we) begin
            cmp_q[TIME_W-1:BUS_W] <= wdata;
        end
    end

    // Timer level registered from the unsigned deadline comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= 1'b0;
        end else begin
            timer_q <= (cmp_q <= time_now);
        end
    end

endmodule

// File: rtl/core_timer_unit.sv
// Module: core_timer_unit
// Core-local timer and software-interrupt unit on a 32-bit register bus.
// Assumes single-clock requests, aligned 32-bit little-endian words.
// Read data and error pulse are registered one clock after bus_req.
module core_timer_unit
    import ctu_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_HARTS = 4,
    parameter logic [ADDR_W-1:0] SWI_BASE  = 16'h1000,
    parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h4000,
    parameter logic [ADDR_W-1:0] TIME_BASE = 16'hBFF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_err,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);

    localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    ctu_region_e                  dec_region;
    logic [HART_W-1:0]            dec_hart;
    logic [TIME_W-1:0]            time_q;
    logic [TIME_W-1:0]            cmp_arr [NUM_HARTS];
    logic [NUM_HARTS*TIME_W-1:0]  cmp_flat;
    logic                         wr_req;
    logic [BUS_W-1:0]             rdata_d;
    logic [BUS_W-1:0]             rdata_q;
    logic                         err_q;

    ctu_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_HARTS (NUM_HARTS),
        .HART_W    (HART_W),
        .SWI_BASE  (SWI_BASE),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE)
    ) u_decode (
        .addr   (bus_addr),
        .region (dec_region),
        .hart   (dec_hart)
    );

    ctu_time_base #(
        .TIME_W (TIME_W)
    ) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .time_q  (time_q)
    );

    // Write qualifier shared by all harts
    always_comb wr_req = bus_req && bus_we;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic sel;
        // This hart is addressed
        always_comb sel = wr_req && (dec_hart == HART_W'(h));

        ctu_hart_slot #(
            .BUS_W  (BUS_W),
            .TIME_W (TIME_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .swi_we    (sel && (dec_region == RG_SWI)),
            .cmp_lo_we (sel && (dec_region == RG_CMP_LO)),
            .cmp_hi_we (sel && (dec_region == RG_CMP_HI)),
            .wdata     (bus_wdata),
            .time_now  (time_q),
            .soft_q    (soft_irq[h]),
            .timer_q   (timer_irq[h]),
            .cmp_q     (cmp_arr[h])
        );

        // Flattened deadline view for the checker
        always_comb cmp_flat[h*TIME_W +: TIME_W] = cmp_arr[h];
    end

    // Read multiplexer over the decoded region
    always_comb begin
        rdata_d = '0;
        case (dec_region)
            RG_SWI:     rdata_d = {{(BUS_W-1){1'b0}}, soft_irq[dec_hart]};
            RG_CMP_LO:  rdata_d = cmp_arr[dec_hart][BUS_W-1:0];
            RG_CMP_HI:  rdata_d = cmp_arr[dec_hart][TIME_W-1:BUS_W];
            RG_TIME_LO: rdata_d = time_q[BUS_W-1:0];
            RG_TIME_HI: rdata_d = time_q[TIME_W-1:BUS_W];
            default:    rdata_d = '0;
        endcase
    end

    // Register read data for read requests only; zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= (bus_req && !bus_we) ? rdata_d : '0;
        end
    end

    // One-clock error pulse for bad accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bus_req && access_faults(dec_region, bus_we);
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

endmodule

// File: rtl/ctu_checker.sv
// Module: ctu_checker
// Temporal properties of core_timer_unit, attached by bind below.
module ctu_checker
    import ctu_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int HART_W    = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick_en,
    input logic                        bus_req,
    input logic                        bus_we,
    input logic [31:0]                 bus_wdata,
    input logic [31:0]                 bus_rdata,
    input logic                        bus_err,
    input ctu_region_e                 region,
    input logic [HART_W-1:0]           hart,
    input logic [TIME_W-1:0]           time_q,
    input logic [NUM_HARTS*TIME_W-1:0] cmp_flat,
    input logic [NUM_HARTS-1:0]        soft_irq
);

    assert_tick_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> time_q == $past(time_q) + 64'd1);

    // R7: bus writes never move the counter; only tick_en does
    assert_time_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(time_q));

    assert_cmp_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we) |=> $stable(cmp_flat));

    assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_err);

    assert_err_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == 32'd0);

    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> bus_rdata == 32'd0);

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
        assert_swi_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_req && bus_we && region == RG_SWI && hart == HART_W'(h))
            |=> soft_irq[h] == ($past(bus_wdata) != 32'd0));
    end

endmodule

bind core_timer_unit ctu_checker #(
    .NUM_HARTS (NUM_HARTS),
    .HART_W    (HART_W)
) u_ctu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .region    (dec_region),
    .hart      (dec_hart),
    .time_q    (time_q),
    .cmp_flat  (cmp_flat),
    .soft_irq  (soft_irq)
);

// File: tb/test_core_timer_unit.sv
module test_core_timer_unit;

    localparam int          N    = 4;
    localparam logic [15:0] SWI  = 16'h1000;
    localparam logic [15:0] CMP  = 16'h4000;
    localparam logic [15:0] TIMB = 16'hBFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [N-1:0] timer_irq;
    logic [N-1:0] soft_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] time_m = '0;
    logic [63:0] cmp_m [N];
    logic        swi_m [N];

    always #2 clk = ~clk;

    core_timer_unit i_core_timer_unit (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [15:0] a);
        int o;
        if (a >= SWI && a < SWI + 16'(4*N)) begin
            o = int'(a - SWI);
            if (o % 4 == 0) return {31'd0, swi_m[o/4]};
            return 32'd0;
        end
        if (a >= CMP && a < CMP + 16'(8*N)) begin
            o = int'(a - CMP);
            if (o % 8 == 0) return cmp_m[o/8][31:0];
            if (o % 8 == 4) return cmp_m[o/8][63:32];
            return 32'd0;
        end
        if (a == TIMB) return time_m[31:0];
        if (a == TIMB + 16'd4) return time_m[63:32];
        return 32'd0;
    endfunction

    function automatic bit model_bad(input logic [15:0] a, input bit we);
        int o;
        if (a >= SWI && a < SWI + 16'(4*N)) begin
            o = int'(a - SWI);
            return (o % 4 != 0);
        end
        if (a >= CMP && a < CMP + 16'(8*N)) begin
            o = int'(a - CMP);
            return (o % 4 != 0);
        end
        if (a == TIMB || a == TIMB + 16'd4) return we;
        return 1'b1;
    endfunction

    function automatic string tag_of(input logic [15:0] a, input bit we);
        if (model_bad(a, we)) return we ? "R9 write ignored" : "R9 read zero";
        if (a >= SWI && a < SWI + 16'(4*N)) return we ? "R1" : "R2";
        if (a >= CMP && a < CMP + 16'(8*N)) return we ? "R4" : "R3";
        return "R6";
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [31:0] d);
        int o;
        if (model_bad(a, 1'b1)) return;
        if (a >= SWI && a < SWI + 16'(4*N)) begin
            o = int'(a - SWI);
            swi_m[o/4] = (d != 0);
        end else if (a >= CMP && a < CMP + 16'(8*N)) begin
            o = int'(a - CMP);
            if (o % 8 == 0) cmp_m[o/8][31:0] = d;
            else cmp_m[o/8][63:32] = d;
        end
    endtask

    task automatic check_irqs();
        @(negedge clk);
        for (int h = 0; h < N; h++) begin
            check(timer_irq[h] === (cmp_m[h] <= time_m), "R5 timer level", 64'(timer_irq[h]), 64'(cmp_m[h] <= time_m));
            check(soft_irq[h] === swi_m[h], "R1 soft level", 64'(soft_irq[h]), 64'(swi_m[h]));
        end
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [31:0] d);
        logic [31:0] er;
        bit eb;
        string tg;
        er = we ? 32'd0 : model_read(a);
        eb = model_bad(a, we);
        tg = tag_of(a, we);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        check(bus_rdata === er, tg, 64'(bus_rdata), 64'(er));
        check(bus_err === eb, "R10 error pulse", 64'(bus_err), 64'(eb));
        if (we) model_write(a, d);
        check_irqs();
        check(bus_err === 1'b0, "R10 single cycle", 64'(bus_err), 64'd0);
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        time_m += 64'(n);
    endtask

    function automatic logic [15:0] rand_addr();
        int h;
        int k;
        h = int'($urandom % N);
        case ($urandom % 7)
            0: return SWI + 16'(4*h);
            1: return SWI + 16'(4*h) + 16'(1 + $urandom % 3);
            2: return CMP + 16'(8*h);
            3: return CMP + 16'(8*h + 4);
            4: begin
                k = 1 + int'($urandom % 7);
                if (k == 4) k = 5;
                return CMP + 16'(8*h + k);
            end
            5: return TIMB + 16'(4 * ($urandom % 2));
            default: return 16'h8000 + 16'(4 * ($urandom % 256));
        endcase
    endfunction

    initial begin
        logic [63:0] t;
        logic [15:0] a;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int h = 0; h < N; h++) begin cmp_m[h] = '0; swi_m[h] = 1'b0; end

        // R11: outputs quiet under reset
        repeat (3) @(negedge clk);
        check(timer_irq === '0, "R11 timer in reset", 64'(timer_irq), 64'd0);
        check(soft_irq === '0, "R11 soft in reset", 64'(soft_irq), 64'd0);
        check(bus_rdata === '0, "R11 rdata in reset", 64'(bus_rdata), 64'd0);
        check(bus_err === 1'b0, "R11 err in reset", 64'(bus_err), 64'd0);
        rst_n = 1'b1;
        // R11: deadline 0 <= time 0 raises all timer lines
        check_irqs();
        access(1'b0, CMP + 16'd8, 32'd0);
        access(1'b0, TIMB, 32'd0);

        // R8: count enabled clocks
        tick(37);
        access(1'b0, TIMB, 32'd0);
        access(1'b0, TIMB + 16'd4, 32'd0);
        // R7: time writes ignored and flagged
        access(1'b1, TIMB, 32'hDEAD_BEEF);
        access(1'b1, TIMB + 16'd4, 32'h1);
        access(1'b0, TIMB, 32'd0);

        // R4: half writes keep the other half
        access(1'b1, CMP + 16'd16, 32'h0000_0005);
        access(1'b1, CMP + 16'd20, 32'h0000_0007);
        access(1'b0, CMP + 16'd16, 32'd0);
        access(1'b0, CMP + 16'd20, 32'd0);
        access(1'b1, CMP + 16'd20, 32'd0);

        // R5: equality boundary with time frozen
        t = time_m;
        access(1'b1, CMP + 16'd4, t[63:32]);
        access(1'b1, CMP, t[31:0]);
        access(1'b1, CMP, t[31:0] + 32'd1);
        tick(1);
        check_irqs();

        // R1/R2: nonzero and zero words on the soft flag
        access(1'b1, SWI + 16'd12, 32'h8000_0000);
        access(1'b0, SWI + 16'd12, 32'd0);
        access(1'b1, SWI + 16'd12, 32'd0);
        access(1'b0, SWI + 16'd12, 32'd0);
        // R9/R10: first address past each region
        access(1'b1, SWI + 16'(4*N), 32'h1);
        access(1'b0, CMP + 16'(8*N), 32'd0);
        access(1'b1, CMP + 16'd2, 32'hFFFF_FFFF);
        access(1'b0, CMP, 32'd0);

        // Random mix of accesses and short tick bursts
        for (int i = 0; i < 600; i++) begin
            a = rand_addr();
            if ($urandom % 2) d = $urandom % 64 + 32'(time_m[5:0]);
            else d = $urandom;
            if ((a - CMP) % 8 == 4 && ($urandom % 3 != 0)) d = 32'd0;
            access(($urandom % 2) == 1, a, d);
            if ($urandom % 8 == 0) begin
                tick(1 + int'($urandom % 4));
                check_irqs();
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule